// File: doc/BRIEF.md
# Host Controller Interrupt Status Register

This block holds the sticky event flags of a USB host controller. It watches six controller events: a change in the root hub status words, a change of the top bit of the frame counter, a non-USB system error, remote wakeup signalling from a device, the start of each frame, and a schedule that runs past the end of its frame. Each event latches its own status bit, and the bit stays set until software clears it. A scheduling overrun also advances a small wrapping counter.

Software reaches the register through a command-coded port. A read command captures the whole 32-bit word into the read data output. A write command clears every defined bit that has a 1 in the write data. The system error flag is the exception. Software cannot clear it, it drives a halt output while it is set, and only a controller reset removes it.

Top module: `hc_int_status`

## Requirements
- R1: A command with code 0x03 and `cmd_valid_i` high loads the current 32-bit status word into `rdata_o` at that clock edge. Any other command, and any cycle without a command, leaves `rdata_o` unchanged.
- R2: Bit positions: overrun=0, start of frame=2, resume=3, system error=4, frame MSB change=5, hub change=6. Bit 1 and bits 31 to 7 always read 0. After reset every bit, `ovr_count_o` and `halt_o` are 0.
- R3: Bit 6 sets when `rh_status_i`, `port1_status_i` or `port2_status_i` differs from its value one cycle earlier. The first cycle after reset only samples and sets nothing.
- R4: Bit 5 sets when bit 15 of `frame_num_i` changes, rising or falling. A change of any lower frame bit alone does not set it.
- R5: Bit 3 sets when `resume_i` goes from 0 to 1 while `host_resume_i` is 0. It does not set while `host_resume_i` is 1, and it does not set while `resume_i` is held high.
- R6: Bit 2 sets in the cycle after a `sof_i` pulse.
- R7: A `sched_ovr_i` pulse sets bit 0 and adds 1 to the 2-bit `ovr_count_o`, which wraps from 3 to 0.
- R8: A `sys_err_i` pulse sets bit 4 and raises `halt_o`. Writes cannot clear bit 4, and only `rst_ni` clears it.
- R9: A write with code 0x83 clears each defined bit other than bit 4 whose `wdata_i` bit is 1. Data bits that are 0, and writes with any other code, change nothing.
- R10: When an event and a clear for the same bit fall in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_i | input | 8 | Command code |
| wdata_i | input | 32 | Write data, 1 bits clear flags |
| rdata_o | output | 32 | Last status word read |
| frame_num_i | input | 16 | Current frame number |
| rh_status_i | input | 32 | Root hub status word |
| port1_status_i | input | 32 | Port 1 status word |
| port2_status_i | input | 32 | Port 2 status word |
| resume_i | input | 1 | Remote resume signalling seen on the bus |
| host_resume_i | input | 1 | Host is in its own resume state |
| sof_i | input | 1 | Start of frame pulse |
| sched_ovr_i | input | 1 | Schedule overrun pulse |
| sys_err_i | input | 1 | System error pulse |
| ovr_count_o | output | 2 | Overrun counter |
| halt_o | output | 1 | Processing halt while system error is set |

## Verification
The assertions assume that every event input is sampled in the register clock domain. Pulse inputs are taken as one event per cycle they are high. The hub words and the frame number are assumed to hold steady unless a real change is meant. The bench drives every input at the falling edge and keeps each pulse high for exactly one cycle. It changes the frame and hub inputs only on purpose, and it holds all inputs steady through reset, so the sampled history seen by the edge detectors is always well defined.

// File: rtl/hcis_pkg.sv
package hcis_pkg;
  localparam int REG_W  = 32;
  localparam int STAT_W = 7;
  localparam int CMD_W  = 8;

  localparam int B_OVERRUN = 0;
  localparam int B_SOF     = 2;
  localparam int B_RESUME  = 3;
  localparam int B_SYSERR  = 4;
  localparam int B_FRMWRAP = 5;
  localparam int B_HUBCHG  = 6;

  localparam logic [CMD_W-1:0] CMD_READ  = 8'h03;
  localparam logic [CMD_W-1:0] CMD_WRITE = 8'h83;

  // implemented bits, and bits software may clear
  localparam logic [STAT_W-1:0] IMPL_MASK = 7'b1111101;
  localparam logic [STAT_W-1:0] CLR_MASK  = 7'b1101101;
endpackage

// File: rtl/hcis_evt_detect.sv
module hcis_evt_detect
  import hcis_pkg::*;
#(
  parameter int FRAME_W = 16,
  parameter int HUB_W   = 32,
  parameter int PORTS   = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [FRAME_W-1:0]       frame_num_i,
  input  logic [HUB_W-1:0]         rh_status_i,
  input  logic [PORTS*HUB_W-1:0]   port_status_i,
  input  logic                     resume_i,
  input  logic                     host_resume_i,
  input  logic                     sof_i,
  input  logic                     sched_ovr_i,
  input  logic                     sys_err_i,
  output logic [STAT_W-1:0]        set_o
);
  localparam int MSB   = FRAME_W - 1;
  localparam int WORDS = PORTS + 1;
  localparam int ALL_W = WORDS * HUB_W;

  logic             primed_q;
  logic             msb_q;
  logic             resume_q;
  logic [ALL_W-1:0] hub_q;
  logic [ALL_W-1:0] hub_d;
  logic [WORDS-1:0] word_chg;
  logic             resume_rise;
  logic             unused_frame_lo;

  assign hub_d = {port_status_i, rh_status_i};
  assign unused_frame_lo = ^frame_num_i[MSB-1:0];

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    assign word_chg[w] = hub_d[w*HUB_W +: HUB_W] != hub_q[w*HUB_W +: HUB_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      primed_q <= 1'b0;
      msb_q    <= 1'b0;
      resume_q <= 1'b0;
      hub_q    <= '0;
    end else begin
      primed_q <= 1'b1;
      msb_q    <= frame_num_i[MSB];
      resume_q <= resume_i;
      hub_q    <= hub_d;
    end
  end

  // host-driven resume never counts as a device wakeup
  assign resume_rise = resume_i & ~resume_q & ~host_resume_i;

  always_comb begin
    set_o            = '0;
    set_o[B_OVERRUN] = sched_ovr_i;
    set_o[B_SOF]     = sof_i;
    set_o[B_RESUME]  = primed_q & resume_rise;
    set_o[B_SYSERR]  = sys_err_i;
    set_o[B_FRMWRAP] = primed_q & (frame_num_i[MSB] ^ msb_q);
    set_o[B_HUBCHG]  = primed_q & (|word_chg);
  end

  // R5
  rd_host_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_resume_i |-> !set_o[B_RESUME]);
  // R5
  rd_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(resume_i) && resume_i) |-> !set_o[B_RESUME]);
  // R4
  fno_steady_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(frame_num_i[MSB]) |-> !set_o[B_FRMWRAP]);
  // R3
  hub_steady_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(rh_status_i) && $stable(port_status_i)) |-> !set_o[B_HUBCHG]);
endmodule

// File: rtl/hcis_sticky_bits.sv
module hcis_sticky_bits
  import hcis_pkg::*;
#(
  parameter int              W    = STAT_W,
  parameter logic [W-1:0]    IMPL = IMPL_MASK,
  parameter logic [W-1:0]    CLRM = CLR_MASK
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] bits_o
);
  for (genvar k = 0; k < W; k++) begin : g_bit
    if (IMPL[k]) begin : g_impl
      logic q;
      logic clr_ok;
      assign clr_ok    = clr_i[k] & CLRM[k];
      assign bits_o[k] = q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= 1'b0;
        else         q <= set_i[k] | (q & ~clr_ok);
      end

      // R10
      set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_i[k] |=> bits_o[k]);
      // R9
      no_spurious_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!bits_o[k] && !set_i[k]) |=> !bits_o[k]);
      if (CLRM[k]) begin : g_clr
        // R9
        clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
          (clr_i[k] && !set_i[k]) |=> !bits_o[k]);
      end else begin : g_hold
        // R8
        hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
          bits_o[k] |=> bits_o[k]);
      end
    end else begin : g_rsvd
      assign bits_o[k] = 1'b0;
    end
  end
endmodule

// File: rtl/hcis_ovr_cnt.sv
module hcis_ovr_cnt #(
  parameter int CNT_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  // R7
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i |=> cnt_o == CNT_W'($past(cnt_o) + 1'b1));
  // R7
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i |=> $stable(cnt_o));
endmodule

// File: rtl/hc_int_status.sv
module hc_int_status
  import hcis_pkg::*;
#(
  parameter int FRAME_W = 16,
  parameter int HUB_W   = 32,
  parameter int CNT_W   = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_valid_i,
  input  logic [CMD_W-1:0]   cmd_i,
  input  logic [REG_W-1:0]   wdata_i,
  output logic [REG_W-1:0]   rdata_o,
  input  logic [FRAME_W-1:0] frame_num_i,
  input  logic [HUB_W-1:0]   rh_status_i,
  input  logic [HUB_W-1:0]   port1_status_i,
  input  logic [HUB_W-1:0]   port2_status_i,
  input  logic               resume_i,
  input  logic               host_resume_i,
  input  logic               sof_i,
  input  logic               sched_ovr_i,
  input  logic               sys_err_i,
  output logic [CNT_W-1:0]   ovr_count_o,
  output logic               halt_o
);
  localparam int PAD_W = REG_W - STAT_W;

  logic              rd_hit;
  logic              wr_hit;
  logic [STAT_W-1:0] set_vec;
  logic [STAT_W-1:0] clr_vec;
  logic [STAT_W-1:0] bits;
  logic [REG_W-1:0]  rdata_q;
  logic              unused_wdata_hi;

  assign rd_hit  = cmd_valid_i && (cmd_i == CMD_READ);
  assign wr_hit  = cmd_valid_i && (cmd_i == CMD_WRITE);
  assign clr_vec = wr_hit ? wdata_i[STAT_W-1:0] : '0;
  assign unused_wdata_hi = ^wdata_i[REG_W-1:STAT_W];

  hcis_evt_detect #(
    .FRAME_W (FRAME_W),
    .HUB_W   (HUB_W),
    .PORTS   (2)
  ) u_detect (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .frame_num_i   (frame_num_i),
    .rh_status_i   (rh_status_i),
    .port_status_i ({port2_status_i, port1_status_i}),
    .resume_i      (resume_i),
    .host_resume_i (host_resume_i),
    .sof_i         (sof_i),
    .sched_ovr_i   (sched_ovr_i),
    .sys_err_i     (sys_err_i),
    .set_o         (set_vec)
  );

  hcis_sticky_bits #(
    .W    (STAT_W),
    .IMPL (IMPL_MASK),
    .CLRM (CLR_MASK)
  ) u_bits (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (set_vec),
    .clr_i  (clr_vec),
    .bits_o (bits)
  );

  hcis_ovr_cnt #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (sched_ovr_i),
    .cnt_o  (ovr_count_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rdata_q <= '0;
    else if (rd_hit) rdata_q <= {{PAD_W{1'b0}}, bits};
  end

  assign rdata_o = rdata_q;
  assign halt_o  = bits[B_SYSERR];

  // R1
  rdata_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_hit |=> $stable(rdata_o));
  // R1
  rdata_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_hit |=> rdata_o[STAT_W-1:0] == $past(bits));
  // R2
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o[REG_W-1:STAT_W] == '0) && !rdata_o[1]);
  // R8
  halt_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |=> halt_o);
  // R8
  halt_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_err_i |=> halt_o);
endmodule

// File: tb/hc_int_status_test.sv
module hc_int_status_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;
  // {events[5:0], clear[7:0], expected[7:0]}
  // events: 0 overrun, 1 sof, 2 resume rise, 3 host resume, 4 frame msb flip, 5 hub word change
  localparam logic [21:0] VEC [NVEC] = '{
    {6'b000010, 8'h00, 8'h04},
    {6'b000001, 8'h00, 8'h01},
    {6'b000100, 8'h00, 8'h08},
    {6'b001100, 8'h00, 8'h00},
    {6'b010000, 8'h00, 8'h20},
    {6'b100000, 8'h00, 8'h40},
    {6'b110111, 8'h00, 8'h6D},
    {6'b000011, 8'h01, 8'h04},
    {6'b000000, 8'h00, 8'h00},
    {6'b110100, 8'h60, 8'h08}
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_valid_i = 1'b0;
  logic [7:0]  cmd_i = 8'h00;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [15:0] frame_num_i = 16'h8001;
  logic [31:0] rh_status_i = 32'h0000_1234;
  logic [31:0] port1_status_i = 32'h0000_0101;
  logic [31:0] port2_status_i = 32'h0000_0202;
  logic        resume_i = 1'b0;
  logic        host_resume_i = 1'b0;
  logic        sof_i = 1'b0;
  logic        sched_ovr_i = 1'b0;
  logic        sys_err_i = 1'b0;
  logic [1:0]  ovr_count_o;
  logic        halt_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [1:0] cnt_model = 2'd0;
  logic [31:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  hc_int_status uut (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_valid_i(cmd_valid_i), .cmd_i(cmd_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .frame_num_i(frame_num_i),
    .rh_status_i(rh_status_i), .port1_status_i(port1_status_i),
    .port2_status_i(port2_status_i), .resume_i(resume_i),
    .host_resume_i(host_resume_i), .sof_i(sof_i), .sched_ovr_i(sched_ovr_i),
    .sys_err_i(sys_err_i), .ovr_count_o(ovr_count_o), .halt_o(halt_o)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic do_cmd(input logic [7:0] code, input logic [31:0] data);
    cmd_valid_i = 1'b1; cmd_i = code; wdata_i = data;
    @(negedge clk);
    cmd_valid_i = 1'b0; cmd_i = 8'h00; wdata_i = '0;
  endtask

  task automatic do_read(output logic [31:0] v);
    do_cmd(8'h03, 32'h0);
    v = rdata_o;
  endtask

  task automatic apply_ev(input logic [5:0] ev);
    sched_ovr_i   = ev[0];
    sof_i         = ev[1];
    resume_i      = ev[2];
    host_resume_i = ev[3];
    if (ev[4]) frame_num_i = (frame_num_i ^ 16'h8000) + 16'd1;
    if (ev[5]) rh_status_i = rh_status_i + 32'd1;
    if (ev[0]) cnt_model = cnt_model + 2'd1;
    @(negedge clk);
    sched_ovr_i = 1'b0; sof_i = 1'b0; resume_i = 1'b0; host_resume_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    // reset with nonzero hub words and frame msb high: R2, R3 priming
    repeat (3) @(negedge clk);
    check("R2 rdata at reset", rdata_o, 32'h0);
    check("R2 count at reset", {30'h0, ovr_count_o}, 32'h0);
    check("R2 halt at reset", {31'h0, halt_o}, 32'h0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    do_read(rv);
    check("R3 no event on first sample after reset", rv, 32'h0);

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      apply_ev(VEC[i][21:16]);
      if (VEC[i][15:8] != 8'h00) do_cmd(8'h83, {24'h0, VEC[i][15:8]});
      do_read(rv);
      check($sformatf("R9 vector %0d status", i), rv, {24'h0, VEC[i][7:0]});
      do_cmd(8'h83, 32'hFFFF_FFFF);
      check($sformatf("R7 vector %0d count", i), {30'h0, ovr_count_o}, {30'h0, cnt_model});
    end
    do_read(rv);
    check("R9 write of ones clears all", rv, 32'h0);

    // R1: non-read commands keep rdata_o
    apply_ev(6'b000010);
    do_cmd(8'h04, 32'h0);
    check("R1 other code keeps rdata", rdata_o, 32'h0);
    do_cmd(8'h83, 32'h0);
    check("R1 write keeps rdata", rdata_o, 32'h0);
    @(negedge clk);
    check("R1 idle keeps rdata", rdata_o, 32'h0);
    do_read(rv);
    check("R6 sof latched", rv, 32'h04);

    // R9: wrong code and zero data change nothing
    do_cmd(8'h84, 32'hFF);
    do_read(rv);
    check("R9 wrong write code ignored", rv, 32'h04);
    do_cmd(8'h83, 32'hFFFF_FF7B);
    do_read(rv);
    check("R9 zero data bit ignored", rv, 32'h04);
    do_cmd(8'h83, 32'h04);
    do_read(rv);
    check("R9 single bit clear", rv, 32'h0);

    // R10: event and clear together
    sof_i = 1'b1; sched_ovr_i = 1'b1; cnt_model = cnt_model + 2'd1;
    do_cmd(8'h83, 32'h05);
    sof_i = 1'b0; sched_ovr_i = 1'b0;
    do_read(rv);
    check("R10 event beats clear", rv, 32'h05);
    do_cmd(8'h83, 32'hFF);

    // R4: low frame bits only
    frame_num_i = frame_num_i + 16'd3;
    @(negedge clk); @(negedge clk);
    do_read(rv);
    check("R4 low frame bits no flag", rv, 32'h0);

    // R5: held resume, host then released
    host_resume_i = 1'b1; resume_i = 1'b1;
    @(negedge clk);
    host_resume_i = 1'b0;
    repeat (2) @(negedge clk);
    do_read(rv);
    check("R5 held resume no flag", rv, 32'h0);
    resume_i = 1'b0;
    @(negedge clk);
    resume_i = 1'b1;
    @(negedge clk);
    resume_i = 1'b0;
    do_read(rv);
    check("R5 fresh resume rise", rv, 32'h08);
    do_cmd(8'h83, 32'hFF);

    // R3: each port word
    port1_status_i = port1_status_i ^ 32'h8000_0000;
    repeat (2) @(negedge clk);
    do_read(rv);
    check("R3 port1 change", rv, 32'h40);
    do_cmd(8'h83, 32'hFF);
    port2_status_i = port2_status_i + 32'd1;
    repeat (2) @(negedge clk);
    do_read(rv);
    check("R3 port2 change", rv, 32'h40);
    do_cmd(8'h83, 32'hFF);

    // R7: wrap to zero
    while (cnt_model != 2'd3) apply_ev(6'b000001);
    check("R7 count at three", {30'h0, ovr_count_o}, 32'd3);
    apply_ev(6'b000001);
    check("R7 count wraps to zero", {30'h0, ovr_count_o}, 32'd0);
    do_read(rv);
    check("R7 overrun flag", rv, 32'h01);
    do_cmd(8'h83, 32'hFF);

    // R8: system error sticky
    sys_err_i = 1'b1;
    @(negedge clk);
    sys_err_i = 1'b0;
    do_read(rv);
    check("R8 error flag", rv, 32'h10);
    check("R8 halt raised", {31'h0, halt_o}, 32'h1);
    do_cmd(8'h83, 32'hFFFF_FFFF);
    do_read(rv);
    check("R8 error survives write", rv, 32'h10);
    check("R8 halt survives write", {31'h0, halt_o}, 32'h1);
    do_reset();
    do_read(rv);
    check("R8 reset clears error", rv, 32'h0);
    check("R8 reset clears halt", {31'h0, halt_o}, 32'h0);
    check("R2 reset clears count", {30'h0, ovr_count_o}, 32'h0);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule